// File: doc/BRIEF.md
# Predicated Vector Element Sequencer

This block executes one vector instruction at a time over a vector register of up to `MVL` integer elements, handling one element per clock. A length command clamps a requested remaining element count to the register capacity. It returns the granted length straight away and keeps it as the active length for later instructions. Software can strip-mine a loop of any trip count this way: it subtracts each grant from the count and repeats until the count reaches zero.

Three element-wise operations run under the active length. The first compares each element with a scalar for inequality and writes the results into an internal predicate register. The second subtracts the scalar from each element, but only where the predicate bit is set. The third subtracts the scalar from every element. The vector register file lives outside the block. The sequencer drives a read port and a write port into it, sees read data in the same cycle, and emits a one-cycle completion pulse when an instruction finishes.

Top module: `vseq_top`

## Requirements
- R1: During and right after reset: `cmd_ready`=1, `vl_cur`=MVL, `pred_mask`=0, and `done`, `rd_en`, `wr_en` and `grant_valid` are all 0.
- R2: A length command (`cmd_op`=2'b00) that is accepted drives `grant_valid`=1 and `grant_len`=min(MVL, `cmd_count`) in the same cycle. From the next cycle, `vl_cur` holds that value.
- R3: A length command finishes in its accept cycle. It reads no element, writes no element and gives no `done`. Repeated length commands, each on the count left after the previous grant, split any count into full grants followed by one remainder.
- R4: A vector command (`cmd_op`≠2'b00) accepted at clock edge E reads element i of register `cmd_vs` in the cycle after edge E+i, for i = 0 .. vl−1. In those cycles `rd_en`=1, `rd_reg`=`cmd_vs` and `rd_idx`=i.
- R5: Compare-not-equal (`cmd_op`=2'b01) sets `pred_mask[i]` to 1 when element i differs from the scalar and to 0 when it is equal, for each i < vl. It leaves the predicate bits at or above vl unchanged and writes no element.
- R6: Masked subtract (`cmd_op`=2'b10) writes `vd[i]` = `vs[i]` − scalar (modulo 2^EW) only for i < vl with `pred_mask[i]`=1. Every other element keeps its value.
- R7: Unmasked subtract (`cmd_op`=2'b11) writes `vd[i]` = `vs[i]` − scalar (modulo 2^EW) for every i < vl. No element at or above vl changes.
- R8: No element index at or above the active length is ever read or written.
- R9: `done` is a single-cycle pulse in the cycle after the last element's cycle, that is vl+1 edges after the accept edge. With vl=0 it comes one edge after accept and no element is read.
- R10: `cmd_ready` is 0 while a vector command runs. A command presented then is ignored: it gives no grant and does not change `vl_cur`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | 00 length, 01 compare-not-equal, 10 masked subtract, 11 subtract |
| cmd_vd | input | RW | Destination register |
| cmd_vs | input | RW | Source register |
| cmd_scalar | input | EW | Scalar operand |
| cmd_count | input | NW | Requested remaining element count (length command) |
| cmd_ready | output | 1 | Idle, a command will be accepted |
| grant_valid | output | 1 | Length command accepted this cycle |
| grant_len | output | LW | Granted length, min(MVL, cmd_count) |
| vl_cur | output | LW | Active vector length |
| rd_en | output | 1 | Element read this cycle |
| rd_reg | output | RW | Register being read |
| rd_idx | output | IW | Element being read |
| rd_data | input | EW | Read data, valid in the same cycle |
| wr_en | output | 1 | Element write this cycle |
| wr_reg | output | RW | Register being written |
| wr_idx | output | IW | Element being written |
| wr_data | output | EW | Write data |
| pred_mask | output | MVL | Predicate register contents |
| done | output | 1 | Vector command finished (one cycle) |

## Verification
The length command is tried with counts of zero, one, exactly MVL, MVL+1 and far above MVL, which separates a correct clamp from off-by-one or truncating ones. A strip-mining run of 75 elements checks the sequence of grants and the subtracts it drives. Register contents mix small values, so compares see both equal and unequal elements. Masked subtracts after such compares show whether the predicate gates writes element by element and whether bits above the active length survive. Runs with vl of 0, 1 and full length, plus a command poked in while busy, check the timing edges of the sequence and the done pulse.

// File: rtl/vseq_pkg.sv
// Shared types for the vector element sequencer.
package vseq_pkg;
    // Command opcodes; encodings are visible at the cmd_op port.
    typedef enum logic [1:0] {
        OP_SETLEN = 2'b00,
        OP_CMPNE  = 2'b01,
        OP_SUBM   = 2'b10,
        OP_SUB    = 2'b11
    } vop_e;
endpackage

// File: rtl/vseq_len.sv
// Length clamp: grants min(MVL, req).
// Assumes NW >= LW so that the cap fits in the request width.
module vseq_len #(
    parameter int MVL = 32,
    parameter int NW  = 16,
    parameter int LW  = 6
) (
    input  logic [NW-1:0] req,
    output logic [LW-1:0] grant
);
    // Pure combinational compare-and-select.
    always_comb begin
        if (req > NW'(MVL)) grant = LW'(MVL);
        else                grant = LW'(req);
    end
endmodule

// File: rtl/vseq_ctrl.sv
// Element sequencer: steps an index from 0 to len-1, one per clock,
// after start; pulses done the cycle after the last element.
// Assumes start is only raised while not busy.
module vseq_ctrl #(
    parameter int LW = 6,
    parameter int IW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [LW-1:0] len,
    output logic          busy,
    output logic [IW-1:0] idx,
    output logic          done
);
    logic          busy_q;
    logic [IW-1:0] idx_q;
    logic [LW-1:0] len_q;
    logic          done_q;
    logic          last;

    // Last element of the current run.
    assign last = busy_q && ((LW'(idx_q) + LW'(1)) == len_q);

    // Run state, index and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            len_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                len_q <= len;
                idx_q <= '0;
                if (len == '0) done_q <= 1'b1;
                else           busy_q <= 1'b1;
            end else if (busy_q) begin
                if (last) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    idx_q <= idx_q + IW'(1);
                end
            end
        end
    end

    assign busy = busy_q;
    assign idx  = idx_q;
    assign done = done_q;
endmodule

// File: rtl/vseq_pred.sv
// Predicate register: one flop per element, written one bit at a time.
// Assumes widx < MVL whenever we is high.
module vseq_pred #(
    parameter int MVL = 32,
    parameter int IW  = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [IW-1:0]  widx,
    input  logic           wbit,
    output logic [MVL-1:0] bits
);
    for (genvar g = 0; g < MVL; g++) begin : g_bit
        // Bit g clears on reset and loads on a write addressed to it.
        always_ff @(posedge clk) begin
            if (!rst_n)                          bits[g] <= 1'b0;
            else if (we && (widx == IW'(g)))     bits[g] <= wbit;
        end
    end
endmodule

// File: rtl/vseq_top.sv
// Predicated vector element sequencer. Accepts one command while idle:
// a length command clamps the requested count to MVL, and vector commands
// walk the active length one element per clock against an external
// register file with same-cycle read data.
module vseq_top
    import vseq_pkg::*;
#(
    parameter int MVL  = 32,
    parameter int EW   = 16,
    parameter int NREG = 8,
    parameter int NW   = 16,
    localparam int LW  = $clog2(MVL + 1),
    localparam int IW  = $clog2(MVL),
    localparam int RW  = $clog2(NREG)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_valid,
    input  logic [1:0]     cmd_op,
    input  logic [RW-1:0]  cmd_vd,
    input  logic [RW-1:0]  cmd_vs,
    input  logic [EW-1:0]  cmd_scalar,
    input  logic [NW-1:0]  cmd_count,
    output logic           cmd_ready,
    output logic           grant_valid,
    output logic [LW-1:0]  grant_len,
    output logic [LW-1:0]  vl_cur,
    output logic           rd_en,
    output logic [RW-1:0]  rd_reg,
    output logic [IW-1:0]  rd_idx,
    input  logic [EW-1:0]  rd_data,
    output logic           wr_en,
    output logic [RW-1:0]  wr_reg,
    output logic [IW-1:0]  wr_idx,
    output logic [EW-1:0]  wr_data,
    output logic [MVL-1:0] pred_mask,
    output logic           done
);
    vop_e          op_in, op_q;
    logic          accept, start, busy;
    logic [IW-1:0] idx;
    logic [LW-1:0] vl_q;
    logic [RW-1:0] vd_q, vs_q;
    logic [EW-1:0] sc_q;
    logic          pred_we;

    assign op_in     = vop_e'(cmd_op);
    assign cmd_ready = !busy;
    assign accept    = cmd_valid && !busy;
    assign start     = accept && (op_in != OP_SETLEN);

    vseq_len #(.MVL(MVL), .NW(NW), .LW(LW)) u_len (
        .req   (cmd_count),
        .grant (grant_len)
    );

    assign grant_valid = accept && (op_in == OP_SETLEN);

    // Active length register, loaded by an accepted length command.
    always_ff @(posedge clk) begin
        if (!rst_n)           vl_q <= LW'(MVL);
        else if (grant_valid) vl_q <= grant_len;
    end

    // Operand capture for the vector command being run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q <= OP_SETLEN;
            vd_q <= '0;
            vs_q <= '0;
            sc_q <= '0;
        end else if (start) begin
            op_q <= op_in;
            vd_q <= cmd_vd;
            vs_q <= cmd_vs;
            sc_q <= cmd_scalar;
        end
    end

    vseq_ctrl #(.LW(LW), .IW(IW)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .len   (vl_q),
        .busy  (busy),
        .idx   (idx),
        .done  (done)
    );

    assign pred_we = busy && (op_q == OP_CMPNE);

    vseq_pred #(.MVL(MVL), .IW(IW)) u_pred (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (pred_we),
        .widx  (idx),
        .wbit  (rd_data != sc_q),
        .bits  (pred_mask)
    );

    // Element datapath: read source, subtract scalar, gate write by op and predicate.
    always_comb begin
        rd_en   = busy;
        rd_reg  = vs_q;
        rd_idx  = idx;
        wr_reg  = vd_q;
        wr_idx  = idx;
        wr_data = rd_data - sc_q;
        wr_en   = busy && ((op_q == OP_SUB) || ((op_q == OP_SUBM) && pred_mask[idx]));
    end

    assign vl_cur = vl_q;
endmodule

// File: rtl/vseq_checker.sv
// Temporal checks on the sequencer's ports; attached by bind below.
module vseq_checker #(
    parameter int MVL = 32,
    parameter int NW  = 16,
    parameter int LW  = 6,
    parameter int IW  = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NW-1:0] cmd_count,
    input logic          cmd_ready,
    input logic          grant_valid,
    input logic [LW-1:0] grant_len,
    input logic [LW-1:0] vl_cur,
    input logic          rd_en,
    input logic [IW-1:0] rd_idx,
    input logic          wr_en,
    input logic [IW-1:0] wr_idx,
    input logic          done
);
    // R2: a grant never exceeds the cap or the request
    a_r2_grant_bound: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (grant_len <= LW'(MVL)) && (NW'(grant_len) <= cmd_count));

    // R4: element index advances by one per cycle within a run
    a_r4_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en)) |-> (rd_idx == $past(rd_idx) + IW'(1)));

    // R8: reads stay below the active length
    a_r8_rd_range: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (LW'(rd_idx) < vl_cur));

    // R8: writes stay below the active length and only in element cycles
    a_r8_wr_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (rd_en && (LW'(wr_idx) < vl_cur)));

    // R9: done lasts one cycle
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: the end of an element run is marked by done
    a_r9_done_after: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_en) |-> done);

    // R10: not ready while elements are being processed
    a_r10_busy_ready: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !cmd_ready);

    // R10: active length cannot change during a run
    a_r10_vl_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en)) |-> $stable(vl_cur));
endmodule

bind vseq_top vseq_checker #(.MVL(MVL), .NW(NW), .LW(LW), .IW(IW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_count   (cmd_count),
    .cmd_ready   (cmd_ready),
    .grant_valid (grant_valid),
    .grant_len   (grant_len),
    .vl_cur      (vl_cur),
    .rd_en       (rd_en),
    .rd_idx      (rd_idx),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .done        (done)
);

// File: tb/vseq_top_test.sv
module vseq_top_test;
    localparam int MVL  = 32;
    localparam int EW   = 16;
    localparam int NREG = 8;
    localparam int NW   = 16;
    localparam int LW   = $clog2(MVL + 1);
    localparam int IW   = $clog2(MVL);
    localparam int RW   = $clog2(NREG);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cmd_valid = 1'b0;
    logic [1:0]     cmd_op = '0;
    logic [RW-1:0]  cmd_vd = '0, cmd_vs = '0;
    logic [EW-1:0]  cmd_scalar = '0;
    logic [NW-1:0]  cmd_count = '0;
    logic           cmd_ready, grant_valid, rd_en, wr_en, done;
    logic [LW-1:0]  grant_len, vl_cur;
    logic [RW-1:0]  rd_reg, wr_reg;
    logic [IW-1:0]  rd_idx, wr_idx;
    logic [EW-1:0]  rd_data, wr_data;
    logic [MVL-1:0] pred_mask;

    logic [EW-1:0]  rf     [NREG][MVL];
    logic [EW-1:0]  exp_rf [NREG][MVL];
    logic [MVL-1:0] exp_pred;
    int             exp_vl;
    int             checks = 0, fails = 0, wd = 0;

    always #5 clk = ~clk;

    vseq_top #(.MVL(MVL), .EW(EW), .NREG(NREG), .NW(NW)) uut (.*);

    // Register file model seen by the design.
    assign rd_data = rf[rd_reg][rd_idx];
    always @(posedge clk) if (wr_en) rf[wr_reg][wr_idx] <= wr_data;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic int grant_of(input int n);
        return (n > MVL) ? MVL : n;
    endfunction

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            chk(1'b0, "R9", "watchdog expired", wd, 150000);
            finish_run();
        end
    end

    task automatic do_setlen(input int n);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'b00; cmd_count = NW'(n);
        #1;
        chk(grant_valid == 1'b1, "R2", "grant_valid", grant_valid, 1);
        chk(int'(grant_len) == grant_of(n), "R2", "grant_len", grant_len, grant_of(n));
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(int'(vl_cur) == grant_of(n), "R2", "vl_cur", vl_cur, grant_of(n));
        chk(!rd_en && !wr_en && !done && cmd_ready, "R3", "idle after length cmd",
            {rd_en, wr_en, done, cmd_ready}, 4'b0001);
        exp_vl = grant_of(n);
    endtask

    task automatic do_vec(input int op, input int vd, input int vs, input int sc, input bit poke);
        int cyc;
        bit seq_ok, cmp_wrote, poke_granted;
        int mm;
        // Expected result, element by element.
        for (int i = 0; i < exp_vl; i++) begin
            case (op)
                1: exp_pred[i] = (exp_rf[vs][i] != EW'(sc));
                2: if (exp_pred[i]) exp_rf[vd][i] = exp_rf[vs][i] - EW'(sc);
                default: exp_rf[vd][i] = exp_rf[vs][i] - EW'(sc);
            endcase
        end
        @(negedge clk);
        chk(cmd_ready, "R10", "ready when idle", cmd_ready, 1);
        cmd_valid = 1'b1; cmd_op = 2'(op); cmd_vd = RW'(vd); cmd_vs = RW'(vs);
        cmd_scalar = EW'(sc);
        @(negedge clk);
        cmd_valid = 1'b0;
        cyc = 1; seq_ok = 1'b1; cmp_wrote = 1'b0; poke_granted = 1'b0;
        while (!done && cyc < MVL + 4) begin
            if (cyc <= exp_vl) begin
                if (!rd_en || int'(rd_idx) != cyc - 1 || rd_reg != RW'(vs)) seq_ok = 1'b0;
            end else if (rd_en) seq_ok = 1'b0;
            if (op == 1 && wr_en) cmp_wrote = 1'b1;
            if (poke && cyc == 2) begin
                cmd_valid = 1'b1; cmd_op = 2'b00; cmd_count = NW'(3);
                #1;
                if (grant_valid || cmd_ready) poke_granted = 1'b1;
            end
            @(negedge clk);
            cmd_valid = 1'b0;
            cyc++;
        end
        chk(cyc == exp_vl + 1, "R9", "edges from accept to done", cyc, exp_vl + 1);
        chk(seq_ok, "R4", "element read order", seq_ok, 1);
        if (op == 1) chk(!cmp_wrote, "R5", "compare wrote an element", cmp_wrote, 0);
        if (poke) begin
            chk(!poke_granted, "R10", "command accepted while busy", poke_granted, 0);
            chk(int'(vl_cur) == exp_vl, "R10", "vl_cur after ignored cmd", vl_cur, exp_vl);
        end
        @(negedge clk);
        chk(!done, "R9", "done longer than one cycle", done, 0);
        mm = 0;
        for (int r = 0; r < NREG; r++)
            for (int e = 0; e < MVL; e++)
                if (rf[r][e] !== exp_rf[r][e]) mm++;
        case (op)
            1: chk(mm == 0, "R5", "register file changed", mm, 0);
            2: chk(mm == 0, "R6", "masked subtract mismatched elements", mm, 0);
            default: chk(mm == 0, "R7", "subtract mismatched elements", mm, 0);
        endcase
        chk(pred_mask == exp_pred, "R5", "pred_mask", pred_mask, exp_pred);
    endtask

    initial begin
        int seed_dummy;
        int n, steps;
        seed_dummy = $urandom(32'd12345);
        for (int r = 0; r < NREG; r++)
            for (int e = 0; e < MVL; e++) begin
                rf[r][e] = EW'($urandom % 4);
                exp_rf[r][e] = rf[r][e];
            end
        exp_pred = '0;
        exp_vl = MVL;
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(cmd_ready && !done && !rd_en && !wr_en && !grant_valid, "R1", "control outputs",
            {cmd_ready, done, rd_en, wr_en, grant_valid}, 5'b10000);
        chk(int'(vl_cur) == MVL, "R1", "vl_cur", vl_cur, MVL);
        chk(pred_mask == '0, "R1", "pred_mask", pred_mask, 0);
        rst_n = 1'b1;

        // R2 clamp corners
        do_setlen(0);
        do_vec(3, 0, 1, 1, 1'b0);  // R9: vl=0 finishes after one edge
        do_setlen(1);
        do_vec(1, 0, 2, 1, 1'b0);
        do_setlen(33);
        do_setlen(1000);
        do_setlen(MVL);
        do_vec(1, 0, 3, 2, 1'b1);   // full compare, poke while busy (R10)
        do_vec(2, 4, 3, 2, 1'b0);   // masked subtract on that predicate (R6)
        do_setlen(5);
        do_vec(1, 0, 5, 0, 1'b0);   // R5: bits at or above 5 keep values
        do_vec(2, 5, 5, 1, 1'b0);
        do_vec(3, 6, 6, 3, 1'b1);   // R7, R8 with in-place update

        // R3: strip-mine 75 elements
        n = 75; steps = 0;
        while (n > 0 && steps < 10) begin
            int g;
            g = grant_of(n);
            do_setlen(n);
            do_vec(3, 7, 7, 1, 1'b0);
            n -= g; steps++;
        end
        chk(steps == 3, "R3", "strip-mine grant count", steps, 3);
        chk(int'(vl_cur) == 11, "R3", "final remainder grant", vl_cur, 11);

        // Random mix
        for (int k = 0; k < 60; k++) begin
            int sel;
            sel = $urandom % 8;
            if (sel < 2) do_setlen($urandom % 48);
            else do_vec(1 + ($urandom % 3), $urandom % NREG, $urandom % NREG,
                        $urandom % 4, exp_vl >= 2 && ($urandom % 4 == 0));
        end
        finish_run();
    end
endmodule